// File: doc/BRIEF.md
# Serial Crosspoint Program and Readback Port

This block is the control-side serial port of a crosspoint switch. Program words arrive one bit per clock on a serial input and enter a 13-bit shift register. Each word holds a 7-bit output address followed by a 6-bit input address. A load strobe on the final bit issues a one-cycle write command, carrying the address and selection, toward the switch core's pending program registers.

Readback reuses the same shift register in place. The host shifts in the 7-bit output address it wants to query, then six dummy bits. It raises the read strobe together with the last dummy bit. On that edge the port sends a read request with the address to the core and captures the returned input selection into the six low register positions. The dummy bits are overwritten. The complete word then leaves the port, MSB first, on a separate serial output.

Top module: `sp_serial_port`

## Requirements
- R1: While rst_ni is low the shift register is cleared, sdout_o is 0 and wr_stb_o is 0.
- R2: sdin_i is sampled on each rising edge of clk_i and enters at bit 0 of a 13-bit shift register. Bits shift toward bit 12, so a word is sent MSB first: output-address bit 6 first and input-address bit 0 last.
- R3: A rising edge with load_i high and read_i low makes wr_stb_o high in the following cycle. In that cycle wr_addr_o holds bits 12..6 of the 13 most recent serial bits, and wr_data_o holds bits 5..0.
- R4: wr_stb_o is a single-cycle pulse: it is high only in the cycle after an edge that issued a write.
- R5: When load_i and read_i are both high on the same edge, the read is performed and no write is issued.
- R6: rd_req_o follows read_i. While it is high, rd_addr_o presents the 7 bits shifted in just before the six dummy bits, where the sixth dummy bit is the bit currently on sdin_i.
- R7: On an edge with read_i high, register bits 12..6 receive the queried address and bits 5..0 receive rd_data_i. The dummy bits are discarded.
- R8: sdout_o always shows bit 12 of the shift register. A bit therefore reaches sdout_o 12 edges after it is shifted in, and a read result appears on sdout_o starting with address bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdin_i | input | 1 | Serial program data in |
| load_i | input | 1 | Write strobe, given with the last program bit |
| read_i | input | 1 | Read strobe, given with the last dummy bit |
| rd_data_i | input | 6 | Current input selection returned by the core for rd_addr_o |
| wr_stb_o | output | 1 | One-cycle write command to the core |
| wr_addr_o | output | 7 | Output address of the write command |
| wr_data_o | output | 6 | Input selection of the write command |
| rd_req_o | output | 1 | Read request to the core |
| rd_addr_o | output | 7 | Output address being queried |
| sdout_o | output | 1 | Serial data out |

## Verification
The assertions assume that rd_data_i is valid in the same cycle as rd_req_o, so the core has to answer a read combinationally. They also assume that load_i and read_i are driven only at clock edges and do not glitch between them. The bench drives a model of the core whose answer is a pure function of rd_addr_o. It changes every input only on the falling edge, so the captured selection and all strobe values are settled well before the sampling edge.

// File: rtl/sp_pkg.sv
package sp_pkg;
  parameter int unsigned OUT_AW = 7;
  parameter int unsigned IN_AW  = 6;
  parameter int unsigned WORD_W = OUT_AW + IN_AW;

  typedef struct packed {
    logic [OUT_AW-1:0] oaddr;
    logic [IN_AW-1:0]  isel;
  } prog_word_t;
endpackage

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int unsigned W    = sp_pkg::WORD_W,
  parameter int unsigned CAPW = sp_pkg::IN_AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sdin_i,
  input  logic            cap_i,
  input  logic [CAPW-1:0] cap_data_i,
  output logic [W-1:0]    next_o,
  output logic [W-1:0]    sr_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  assign next_o = {sr_q[W-2:0], sdin_i};

  always_comb begin
    sr_d = next_o;
    // capture overwrites the dummy positions in place
    if (cap_i) sr_d[CAPW-1:0] = cap_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign sr_o = sr_q;

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(cap_i) |-> sr_q[0] == $past(sdin_i));

  a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cap_i) |->
      (sr_q[CAPW-1:0] == $past(cap_data_i)) &&
      (sr_q[W-1:CAPW] == $past(sr_q[W-2:CAPW-1])));
endmodule

// File: rtl/sp_cmd_arb.sv
module sp_cmd_arb #(
  parameter bit READ_WINS = 1'b1
) (
  input  logic load_i,
  input  logic read_i,
  output logic wr_en_o,
  output logic cap_o
);
  generate
    if (READ_WINS) begin : g_read_wins
      assign cap_o   = read_i;
      assign wr_en_o = load_i & ~read_i;
    end else begin : g_load_wins
      assign wr_en_o = load_i;
      assign cap_o   = read_i & ~load_i;
    end
  endgenerate
endmodule

// File: rtl/sp_wr_port.sv
module sp_wr_port #(
  parameter int unsigned AW = sp_pkg::OUT_AW,
  parameter int unsigned DW = sp_pkg::IN_AW,
  localparam int unsigned WW = AW + DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [WW-1:0] word_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= wr_en_i;
      if (wr_en_i) begin
        wr_addr_o <= word_i[WW-1:DW];
        wr_data_o <= word_i[DW-1:0];
      end
    end
  end

  a_r3_write_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(wr_en_i) |->
      wr_stb_o && wr_addr_o == $past(word_i[WW-1:DW]) && wr_data_o == $past(word_i[DW-1:0]));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && wr_stb_o |-> $past(wr_en_i));
endmodule

// File: rtl/sp_serial_port.sv
module sp_serial_port
  import sp_pkg::*;
#(
  parameter int unsigned OAW = OUT_AW,
  parameter int unsigned IAW = IN_AW,
  localparam int unsigned WW = OAW + IAW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sdin_i,
  input  logic           load_i,
  input  logic           read_i,
  input  logic [IAW-1:0] rd_data_i,
  output logic           wr_stb_o,
  output logic [OAW-1:0] wr_addr_o,
  output logic [IAW-1:0] wr_data_o,
  output logic           rd_req_o,
  output logic [OAW-1:0] rd_addr_o,
  output logic           sdout_o
);
  logic          wr_en;
  logic          cap;
  logic [WW-1:0] next_word;
  logic [WW-1:0] sr;

  sp_cmd_arb #(.READ_WINS(1'b1)) u_arb (
    .load_i (load_i),
    .read_i (read_i),
    .wr_en_o(wr_en),
    .cap_o  (cap)
  );

  sp_shifter #(.W(WW), .CAPW(IAW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sdin_i    (sdin_i),
    .cap_i     (cap),
    .cap_data_i(rd_data_i),
    .next_o    (next_word),
    .sr_o      (sr)
  );

  sp_wr_port #(.AW(OAW), .DW(IAW)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .word_i   (next_word),
    .wr_stb_o (wr_stb_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o)
  );

  // the address sits one position below its final place until the capture edge
  assign rd_req_o  = cap;
  assign rd_addr_o = sr[WW-2:IAW-1];
  assign sdout_o   = sr[WW-1];

  a_r5_read_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(read_i) |-> !wr_stb_o);

  a_r8_sdout_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(read_i) |-> sdout_o == $past(sr[WW-2]));
endmodule

// File: tb/tb_sp_serial_port.sv
module tb_sp_serial_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sdin = 1'b0, load = 1'b0, read = 1'b0;
  logic [5:0] rd_data;
  logic       wr_stb, rd_req, sdout;
  logic [6:0] wr_addr, rd_addr;
  logic [5:0] wr_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic       cap_req;
  logic [6:0] cap_addr;

  always #4 clk = ~clk;

  sp_serial_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .sdin_i(sdin), .load_i(load), .read_i(read),
    .rd_data_i(rd_data), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .sdout_o(sdout)
  );

  function automatic logic [5:0] core_sel(input logic [6:0] a);
    return a[6] ? ~a[5:0] : (a[5:0] ^ 6'h15);
  endfunction

  // model of the switch core: answers reads combinationally
  always_comb rd_data = core_sel(rd_addr);

  localparam logic [12:0] VEC [6] = '{
    {7'd4, 6'd22}, {7'd127, 6'd63}, {7'd0, 6'd0},
    {7'd85, 6'd42}, {7'd42, 6'd21}, {7'd63, 6'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_word(input logic [12:0] w, input logic ld, input logic rd);
    for (int i = 12; i >= 0; i--) begin
      sdin = w[i];
      load = (i == 0) ? ld : 1'b0;
      read = (i == 0) ? rd : 1'b0;
      #1;
      if (i == 0) begin
        cap_req  = rd_req;
        cap_addr = rd_addr;
      end
      tick();
    end
    load = 1'b0;
    read = 1'b0;
    sdin = 1'b0;
  endtask

  task automatic read_back(input logic [6:0] a, input logic ld);
    logic [12:0] got;
    send_word({a, 6'h2D}, ld, 1'b1);
    chk(cap_req === 1'b1, "R6 rd_req", cap_req, 1);
    chk(cap_addr === a, "R6 rd_addr", cap_addr, a);
    if (ld) chk(wr_stb === 1'b0, "R5 no write on read+load", wr_stb, 0);
    for (int i = 12; i >= 0; i--) begin
      got[i] = sdout;
      if (i > 0) tick();
    end
    chk(got === {a, core_sel(a)}, "R7 R8 readback word", got, {a, core_sel(a)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sdout === 1'b0, "R1 sdout in reset", sdout, 0);
    chk(wr_stb === 1'b0, "R1 wr_stb in reset", wr_stb, 0);
    rst_ni = 1'b1;
    tick();

    // table-driven writes
    for (int v = 0; v < 6; v++) begin
      send_word(VEC[v], 1'b1, 1'b0);
      chk(wr_stb === 1'b1, "R3 strobe", wr_stb, 1);
      chk(wr_addr === VEC[v][12:6], "R3 addr", wr_addr, VEC[v][12:6]);
      chk(wr_data === VEC[v][5:0], "R3 data", wr_data, VEC[v][5:0]);
      tick();
      chk(wr_stb === 1'b0, "R4 pulse width", wr_stb, 0);
    end

    // shift without strobes: no write, word appears MSB first on sdout
    begin
      logic [12:0] pat, got;
      pat = 13'h1A5B;
      send_word(pat, 1'b0, 1'b0);
      chk(wr_stb === 1'b0, "R4 no strobe without load", wr_stb, 0);
      for (int i = 12; i >= 0; i--) begin
        got[i] = sdout;
        if (i > 0) tick();
      end
      chk(got === pat, "R2 R8 shift order", got, pat);
    end

    // readback in place
    read_back(7'd4, 1'b0);
    read_back(7'd127, 1'b0);
    read_back(7'd0, 1'b0);
    // read and load on the same edge
    read_back(7'd85, 1'b1);

    // asynchronous reset mid-run clears the register
    send_word(13'h1FFF, 1'b0, 1'b0);
    chk(sdout === 1'b1, "R8 ones shifted", sdout, 1);
    rst_ni = 1'b0;
    #1;
    chk(sdout === 1'b0, "R1 async clear", sdout, 0);
    tick();
    rst_ni = 1'b1;
    tick();
    chk(wr_stb === 1'b0, "R1 no strobe after reset", wr_stb, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule